// File: doc/BRIEF.md
# DMA Transfer Address Sequencer

This block produces the source and destination addresses for a memory-to-memory DMA engine. It also produces the per-beat step size. Software programs a read start address, a write start address, a byte count, a one-hot transfer-width selection and two hold flags. A start strobe then captures these values. Each beat that the data path reports as complete moves both addresses forward by the transfer size in bytes. An address whose hold flag is set stays where it is, which is how a peripheral FIFO is read or written. The block also counts the remaining bytes down and gives a single-cycle completion pulse when the count reaches zero.

The transfer size is taken from a five-bit one-hot selection. Each width can only be used if a build-time mask enables it. If the selection has no bit set, more than one bit set, or a bit that the mask disables, the configuration is illegal. The block then refuses the start and reports the error instead of starting. Software is expected to pick the narrower of the two endpoint widths. For example, a 16-bit source feeding a 32-bit destination is run with halfword steps.

Top module: `dma_addr_seq`

## Requirements
- R1: When `go` is high while idle and the configuration is legal, the next cycle shows `busy`=1, `rd_addr`/`wr_addr` equal to the start values, `rem_len` equal to `len_in`, and `step` holding the transfer size in bytes.
- R2: Each cycle with `busy`=1 and `beat_done`=1 adds `step` to `rd_addr`. If `hold_rd` was set at start, `rd_addr` is left unchanged.
- R3: The write address follows the same rule as the read address, under `hold_wr`, independently of `hold_rd`.
- R4: `width_sel` encoding: bit 0 gives 1 byte, bit 1 gives 2, bit 2 gives 4, bit 3 gives 8, bit 4 gives 16.
- R5: A `go` with `width_sel` zero or with more than one bit set raises `cfg_err` for exactly one cycle and leaves the block idle.
- R6: A `go` whose single selected width is cleared in the `WIDTH_EN` parameter (bit order as in R4) raises `cfg_err` for one cycle and leaves the block idle.
- R7: Each beat reduces `rem_len` by `step`, clamping at zero. On the beat that reaches zero, the next cycle shows `busy`=0 and `done`=1, and `done` is high for one cycle only.
- R8: `beat_done` while idle changes no output. `go` while busy is ignored.
- R9: Synchronous `rst` clears `busy`, `done`, `cfg_err`, both addresses, `rem_len` and `step`.
- R10: A legal `go` with `len_in`=0 pulses `done` on the next cycle without entering busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, acted on only while idle |
| rd_start | input | AW | Read start address |
| wr_start | input | AW | Write start address |
| len_in | input | LW | Transfer length in bytes |
| hold_rd | input | 1 | Keep read address fixed |
| hold_wr | input | 1 | Keep write address fixed |
| width_sel | input | 5 | One-hot transfer width (R4) |
| beat_done | input | 1 | One data beat completed |
| rd_addr | output | AW | Current read address |
| wr_addr | output | AW | Current write address |
| rem_len | output | LW | Bytes remaining |
| step | output | 5 | Transfer size in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| cfg_err | output | 1 | Illegal width configuration pulse |

## Verification
The assertions assume that `beat_done` is only meaningful while `busy` is high. They also assume that the start strobe is the only way configuration enters the block, so an address step can be predicted from the step and hold flag captured at start. The stimulus keeps all addresses far below the wrap point of `AW` bits, and it gives lengths up to a few dozen bytes. This means no address overflow is ever required. Illegal widths are applied only together with `go`, so the refusal path is checked against a block that is known to be idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int WSEL_W = 5;
    localparam int STEP_W = 5;

    typedef struct packed {
        logic              hold_rd;
        logic              hold_wr;
        logic [STEP_W-1:0] step;
    } seq_cfg_t;

    function automatic logic [STEP_W-1:0] step_of(input logic [WSEL_W-1:0] sel);
        logic [STEP_W-1:0] s;
        s = '0;
        for (int i = 0; i < WSEL_W; i++)
            if (sel[i]) s = STEP_W'(1 << i);
        return s;
    endfunction

    function automatic logic single_bit(input logic [WSEL_W-1:0] sel);
        return (sel != '0) && ((sel & (sel - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/seq_width_decode.sv
module seq_width_decode
    import dma_seq_pkg::*;
#(
    parameter logic [WSEL_W-1:0] WIDTH_EN = 5'b01111
) (
    input  logic [WSEL_W-1:0] sel,
    output logic [STEP_W-1:0] step_bytes,
    output logic              legal
);
    always_comb begin
        step_bytes = step_of(sel);
        legal      = single_bit(sel) && ((sel & ~WIDTH_EN) == '0);
    end
endmodule

// File: rtl/seq_addr_walker.sv
module seq_addr_walker
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [AW-1:0]     start,
    input  logic              adv,
    input  logic              hold,
    input  logic [STEP_W-1:0] step,
    output logic [AW-1:0]     addr
);
    localparam int PADW = AW - STEP_W;

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= start;
        else if (adv && !hold)
            addr <= addr + {{PADW{1'b0}}, step};
    end
endmodule

// File: rtl/seq_len_tracker.sv
module seq_len_tracker
    import dma_seq_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LW-1:0]     len_in,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    output logic [LW-1:0]     rem,
    output logic              last
);
    localparam int PADW = LW - STEP_W;
    logic [LW-1:0] step_ext;

    always_comb begin
        step_ext = {{PADW{1'b0}}, step};
        last     = rem <= step_ext;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rem <= '0;
        else if (load)
            rem <= len_in;
        else if (adv)
            rem <= last ? '0 : rem - step_ext;
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int                AW       = 32,
    parameter int                LW       = 16,
    parameter logic [WSEL_W-1:0] WIDTH_EN = 5'b01111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [AW-1:0]     rd_start,
    input  logic [AW-1:0]     wr_start,
    input  logic [LW-1:0]     len_in,
    input  logic              hold_rd,
    input  logic              hold_wr,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic              beat_done,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     wr_addr,
    output logic [LW-1:0]     rem_len,
    output logic [STEP_W-1:0] step,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    localparam int NCH = 2;

    seq_cfg_t          cfg_q;
    logic [STEP_W-1:0] dec_step;
    logic              dec_legal;
    logic              accept, load, adv, last;
    logic [AW-1:0]     ch_start [NCH];
    logic [AW-1:0]     ch_addr  [NCH];
    logic              ch_hold  [NCH];

    seq_width_decode #(.WIDTH_EN(WIDTH_EN)) u_dec (
        .sel(width_sel), .step_bytes(dec_step), .legal(dec_legal)
    );

    always_comb begin
        accept      = go && !busy;
        load        = accept && dec_legal;
        adv         = busy && beat_done;
        ch_start[0] = rd_start;
        ch_start[1] = wr_start;
        ch_hold[0]  = cfg_q.hold_rd;
        ch_hold[1]  = cfg_q.hold_wr;
        rd_addr     = ch_addr[0];
        wr_addr     = ch_addr[1];
        step        = cfg_q.step;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        seq_addr_walker #(.AW(AW)) u_walk (
            .clk(clk), .rst(rst), .load(load), .start(ch_start[c]),
            .adv(adv), .hold(ch_hold[c]), .step(cfg_q.step), .addr(ch_addr[c])
        );
    end

    seq_len_tracker #(.LW(LW)) u_len (
        .clk(clk), .rst(rst), .load(load), .len_in(len_in),
        .adv(adv), .step(cfg_q.step), .rem(rem_len), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            cfg_err <= accept && !dec_legal;
            if (load) begin
                cfg_q <= '{hold_rd: hold_rd, hold_wr: hold_wr, step: dec_step};
                if (len_in == '0) done <= 1'b1;
                else              busy <= 1'b1;
            end else if (adv && last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int                AW       = 32,
    parameter int                LW       = 16,
    parameter logic [WSEL_W-1:0] WIDTH_EN = 5'b01111
) (
    input logic              clk,
    input logic              rst,
    input logic              go,
    input logic [WSEL_W-1:0] width_sel,
    input logic              beat_done,
    input logic [AW-1:0]     rd_addr,
    input logic [AW-1:0]     wr_addr,
    input logic [STEP_W-1:0] step,
    input logic              busy,
    input logic              done,
    input logic              cfg_err,
    input logic              hold_rd_q,
    input logic              hold_wr_q
);
    logic bad_sel;
    assign bad_sel = ($countones(width_sel) != 1) || ((width_sel & ~WIDTH_EN) != '0);

    p_rd_advance_r2: assert property (@(posedge clk) disable iff (rst)
        busy && beat_done && !hold_rd_q |=> rd_addr == $past(rd_addr) + AW'($past(step)));
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        busy && beat_done && hold_rd_q |=> $stable(rd_addr));
    p_wr_advance_r3: assert property (@(posedge clk) disable iff (rst)
        busy && beat_done && !hold_wr_q |=> wr_addr == $past(wr_addr) + AW'($past(step)));
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        busy && beat_done && hold_wr_q |=> $stable(wr_addr));
    p_step_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones(step) == 1);
    p_bad_cfg_idle_r5: assert property (@(posedge clk) disable iff (rst)
        go && !busy && bad_sel |=> cfg_err && !busy);
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_idle_beat_r8: assert property (@(posedge clk) disable iff (rst)
        !busy && !go |=> $stable(rd_addr) && $stable(wr_addr));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .LW(LW), .WIDTH_EN(WIDTH_EN)) u_chk (
    .clk(clk), .rst(rst), .go(go), .width_sel(width_sel), .beat_done(beat_done),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .step(step), .busy(busy), .done(done),
    .cfg_err(cfg_err), .hold_rd_q(cfg_q.hold_rd), .hold_wr_q(cfg_q.hold_wr)
);

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst, go, hold_rd, hold_wr, beat_done;
    logic [AW-1:0] rd_start, wr_start, rd_addr, wr_addr;
    logic [LW-1:0] len_in, rem_len;
    logic [4:0] width_sel, step;
    logic busy, done, cfg_err;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_addr_seq #(.AW(AW), .LW(LW), .WIDTH_EN(5'b01111)) dut (.*);

    typedef struct packed {
        logic [31:0] rs;
        logic [31:0] ws;
        logic [15:0] len;
        logic        hr;
        logic        hw;
        logic [4:0]  sel;
        logic [4:0]  stp;
        logic [7:0]  beats;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h1000, 32'h2000, 16'd8,  1'b0, 1'b0, 5'b00001, 5'd1,  8'd8},
        '{32'h0100, 32'h4000, 16'd12, 1'b1, 1'b0, 5'b00100, 5'd4,  8'd3},
        '{32'h3000, 32'h0500, 16'd16, 1'b0, 1'b1, 5'b00010, 5'd2,  8'd8},
        '{32'h8000, 32'h9000, 16'd24, 1'b1, 1'b1, 5'b01000, 5'd8,  8'd3},
        '{32'h0010, 32'h0020, 16'd5,  1'b0, 1'b0, 5'b00100, 5'd4,  8'd2},
        '{32'h0777, 32'h0888, 16'd2,  1'b0, 1'b0, 5'b00001, 5'd1,  8'd2}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [31:0] rs, ws, input logic [15:0] len,
                         input logic hr, hw, input logic [4:0] sel);
        @(negedge clk);
        rd_start = rs; wr_start = ws; len_in = len;
        hold_rd = hr; hold_wr = hw; width_sel = sel; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic beat();
        @(negedge clk);
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; go = 1'b0; beat_done = 1'b0; hold_rd = 1'b0; hold_wr = 1'b0;
        rd_start = '0; wr_start = '0; len_in = '0; width_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(!busy && !done && !cfg_err && rd_addr == 0 && wr_addr == 0 && rem_len == 0 && step == 0,
              "R9 reset", {busy, done, cfg_err, step}, 0);

        for (int v = 0; v < 6; v++) begin
            logic [31:0] er, ew;
            logic [15:0] el;
            start(VECS[v].rs, VECS[v].ws, VECS[v].len, VECS[v].hr, VECS[v].hw, VECS[v].sel);
            check(busy && rd_addr == VECS[v].rs && wr_addr == VECS[v].ws && rem_len == VECS[v].len,
                  "R1 load", rd_addr, VECS[v].rs);
            check(step == VECS[v].stp, "R4 step", step, VECS[v].stp);
            er = VECS[v].rs; ew = VECS[v].ws; el = VECS[v].len;
            for (int b = 0; b < int'(VECS[v].beats); b++) begin
                beat();
                if (!VECS[v].hr) er = er + 32'(VECS[v].stp);
                if (!VECS[v].hw) ew = ew + 32'(VECS[v].stp);
                el = (el <= 16'(VECS[v].stp)) ? 16'd0 : el - 16'(VECS[v].stp);
                check(rd_addr == er, "R2 rd_addr", rd_addr, er);
                check(wr_addr == ew, "R3 wr_addr", wr_addr, ew);
                check(rem_len == el, "R7 rem_len", rem_len, el);
            end
            check(done && !busy, "R7 done", {done, busy}, 2'b10);
            @(negedge clk);
            check(!done, "R7 done single", done, 0);
        end

        // R5 zero and multi-bit selections
        start(32'h10, 32'h20, 16'd8, 1'b0, 1'b0, 5'b00000);
        check(cfg_err && !busy, "R5 zero sel", {cfg_err, busy}, 2'b10);
        @(negedge clk);
        check(!cfg_err, "R5 err single", cfg_err, 0);
        start(32'h10, 32'h20, 16'd8, 1'b0, 1'b0, 5'b00101);
        check(cfg_err && !busy, "R5 multi sel", {cfg_err, busy}, 2'b10);
        // R6 quadword disabled in WIDTH_EN
        start(32'h10, 32'h20, 16'd32, 1'b0, 1'b0, 5'b10000);
        check(cfg_err && !busy, "R6 disabled width", {cfg_err, busy}, 2'b10);

        // R8 beats while idle
        beat();
        check(rd_addr == 32'h0777 + 2 && wr_addr == 32'h0888 + 2 && !busy,
              "R8 idle beat", rd_addr, 32'h0779);
        // R8 go while busy ignored
        start(32'h100, 32'h200, 16'd4, 1'b0, 1'b0, 5'b00001);
        start(32'hAAA, 32'hBBB, 16'd40, 1'b0, 1'b0, 5'b00010);
        check(rd_addr == 32'h100 && rem_len == 4 && step == 1, "R8 go busy", rd_addr, 32'h100);
        beat();
        check(rd_addr == 32'h101, "R8 step kept", rd_addr, 32'h101);

        // R9 reset mid-transfer
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!busy && rd_addr == 0 && rem_len == 0 && step == 0, "R9 mid reset", rd_addr, 0);

        // R10 zero length
        start(32'h40, 32'h50, 16'd0, 1'b0, 1'b0, 5'b00100);
        check(done && !busy, "R10 zero len", {done, busy}, 2'b10);
        @(negedge clk);
        check(!done && !busy, "R10 done single", done, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule